// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block decides when a two-bank DRAM gets refreshed and drives the refresh-related command pins and the clock-enable pin on behalf of the chip's main command sequencer. It keeps a count of refreshes owed. In distributed policy, one refresh is added every refresh interval. In burst policy, the count is set to a full burst at the start of every retention window. The refreshes owed are then issued as auto-refresh commands, each followed by a quiet recovery period of tRC.

To issue commands, the block raises a request towards the sequencer. It waits until the sequencer grants the command bus and reports both banks idle. From that point the block owns the pins. A pending refresh therefore holds off new activates.

A sleep request puts the device into self-refresh. The request is acknowledged only once the device has entered self-refresh. Releasing the sleep request brings the device back out: the clock enable is raised and tRC of quiet cycles follow. Under burst policy, a full recovery burst of refreshes is issued straight after the exit.

Timing is given in nanoseconds and microseconds together with the clock frequency. Every cycle count is derived from these parameters.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is held and right after it, cke_o is 1, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and rf_req_o and sleep_ack_o are 0.
- R2: An auto-refresh is the encoding {cs_n,ras_n,cas_n,we_n} = 0001 with cke_o = 1, held for one cycle. It is driven only in the cycle after a cycle in which rf_gnt_i and banks_idle_i were both 1 and cke_o was 1. With banks_idle_i held at 0, no refresh is issued.
- R3: With policy_burst_i = 0, one refresh becomes owed every INTERVAL_NS of clock time. The owed count saturates at BURST_CNT, so after a long denial at most BURST_CNT refreshes are issued back to back, plus any that fall due while they drain.
- R4: With policy_burst_i = 1, the owed count is set to BURST_CNT once per WINDOW_US window. No refresh is owed before the first window ends, and each window yields exactly BURST_CNT refreshes.
- R5: Between two auto-refreshes there are at least TRC_CYC cycles, start to start, with NOP driven in between. Refreshes that are owed back to back, with the grant held, are spaced by exactly TRC_CYC cycles.
- R6: rf_req_o rises once a refresh or a sleep is pending. It stays high while the block waits for the grant or runs a refresh sequence. It returns to 0 once nothing is owed and the last tRC has elapsed.
- R7: Self-refresh entry is {cs_n,ras_n,cas_n,we_n} = 0001 with cke_o = 0. It is issued after a granted, all-idle cycle while sleep_req_i is 1. A pending sleep takes precedence over owed refreshes, and entry clears the owed count.
- R8: sleep_ack_o is 1 only while the device is in self-refresh. It rises the cycle after the entry command, and cke_o is 0 throughout.
- R9: In self-refresh, changes on rf_gnt_i, banks_idle_i and policy_burst_i have no effect. cke_o stays 0, no command is driven, and the refresh timer does not advance.
- R10: When sleep_req_i falls in self-refresh, cke_o rises at the next clock and sleep_ack_o falls. NOP is then driven for TRC_CYC cycles, and no command follows earlier.
- R11: On exit under burst policy, a recovery burst of BURST_CNT refreshes follows. The first of these comes no earlier than TRC_CYC+1 cycles after the sleep release. Under distributed policy, no refresh follows the exit until a new interval elapses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_burst_i | input | 1 | 0 selects distributed refresh, 1 selects burst refresh |
| banks_idle_i | input | 1 | Both banks idle, from the bank tracker |
| rf_gnt_i | input | 1 | Sequencer hands the command bus to this block |
| sleep_req_i | input | 1 | Request to hold the device in self-refresh |
| rf_req_o | output | 1 | Block needs or holds the command bus |
| sleep_ack_o | output | 1 | Device is in self-refresh |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |

## Verification
On every cycle, the assertions check three properties of the pins. Every refresh or self-refresh entry must follow a granted, all-idle cycle. No refresh may start within tRC of a previous refresh or of a clock-enable rise. The acknowledge and clock-enable must track the sleep request across entry and exit. The owed-count logic is also checked every cycle, for underflow and for the distributed increment.

Only the bench's scenarios can show the counts and the timing. These are how many refreshes each policy issues in a span of time, the saturation after a long denial, the exact spacing inside a burst, and the recovery burst after exit. They also include the absence of a recovery burst under distributed policy, and the fact that the debt is dropped when sleep overrides a pending refresh.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_REQ, ST_AR, ST_TRC, ST_SRE, ST_SELF, ST_SRX
   } rf_state_e;

   // command pins packed as {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP = 4'b0111;
   localparam logic [3:0] CMD_REF = 4'b0001;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
   parameter int INTERVAL_CYC = 1560,
   parameter int WINDOW_CYC   = 3200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic burst_i,
   output logic tick_o
);
   localparam int MAXC = (WINDOW_CYC > INTERVAL_CYC) ? WINDOW_CYC : INTERVAL_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] LIM_DIST  = CW'(INTERVAL_CYC - 1);
   localparam logic [CW-1:0] LIM_BURST = CW'(WINDOW_CYC - 1);

   if (INTERVAL_CYC < 2) begin : g_bad_interval
      $error("rfsh_timer: INTERVAL_CYC must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim    = burst_i ? LIM_BURST : LIM_DIST;
   assign tick_o = !hold_i && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (hold_i || tick_o) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

   // R9: timer does not advance while held for self-refresh
   a_r9_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> cnt == '0);
endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
   parameter int BURST_CNT = 2048,
   localparam int DW = $clog2(BURST_CNT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          burst_i,
   input  logic          take_i,
   input  logic          clr_i,
   input  logic          refill_i,
   output logic [DW-1:0] owed_o
);
   localparam logic [DW:0] CAP = (DW+1)'(BURST_CNT);

   logic [DW:0]   sum;
   logic [DW-1:0] owed_nx;

   always_comb begin
      sum = {1'b0, owed_o} - (DW+1)'(take_i) + (DW+1)'(tick_i && !burst_i);
      if (sum > CAP) sum = CAP;
      if (refill_i || (tick_i && burst_i)) owed_nx = DW'(BURST_CNT);
      else if (clr_i)                      owed_nx = '0;
      else                                 owed_nx = sum[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) owed_o <= '0;
      else        owed_o <= owed_nx;
   end

   // R2: a refresh is only taken when one is owed
   a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> owed_o != '0);
   // R3: a distributed tick below the cap adds exactly one
   a_r3_dist_increment: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !burst_i && !take_i && !clr_i && !refill_i && owed_o < DW'(BURST_CNT))
      |=> owed_o == $past(owed_o) + 1'b1);
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
   import rfsh_pkg::*;
#(
   parameter int TRC_CYC = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       owed_nz_i,
   input  logic       burst_i,
   input  logic       gnt_i,
   input  logic       idle_i,
   input  logic       sleep_req_i,
   output logic       take_o,
   output logic       hold_o,
   output logic       refill_o,
   output logic [3:0] cmd_o,
   output logic       cke_o,
   output logic       req_o,
   output logic       ack_o
);
   localparam int TW = $clog2(TRC_CYC);
   localparam logic [TW-1:0] WAIT_AR = TW'(TRC_CYC - 2);
   localparam logic [TW-1:0] WAIT_SX = TW'(TRC_CYC - 1);

   rf_state_e     st, st_nx;
   logic [TW-1:0] wcnt, wcnt_nx;
   logic          go, want;

   assign go   = gnt_i && idle_i;
   assign want = sleep_req_i || owed_nz_i;

   always_comb begin
      st_nx   = st;
      wcnt_nx = (wcnt != '0) ? wcnt - 1'b1 : wcnt;
      unique case (st)
         ST_IDLE: if (want) st_nx = ST_REQ;
         ST_REQ: begin
            if (go && sleep_req_i)    st_nx = ST_SRE;
            else if (go && owed_nz_i) st_nx = ST_AR;
            else if (!want)           st_nx = ST_IDLE;
         end
         ST_AR: begin
            st_nx   = ST_TRC;
            wcnt_nx = WAIT_AR;
         end
         ST_TRC: if (wcnt == '0) begin
            if (go && owed_nz_i && !sleep_req_i) st_nx = ST_AR;
            else if (want)                       st_nx = ST_REQ;
            else                                 st_nx = ST_IDLE;
         end
         ST_SRE:  st_nx = ST_SELF;
         ST_SELF: if (!sleep_req_i) begin
            st_nx   = ST_SRX;
            wcnt_nx = WAIT_SX;
         end
         ST_SRX:  if (wcnt == '0) st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         wcnt <= '0;
      end else begin
         st   <= st_nx;
         wcnt <= wcnt_nx;
      end
   end

   assign take_o   = (st == ST_AR);
   assign hold_o   = (st == ST_SRE) || (st == ST_SELF) || (st == ST_SRX);
   assign refill_o = (st == ST_SRX) && (wcnt == '0) && burst_i;
   assign cmd_o    = (st == ST_AR || st == ST_SRE) ? CMD_REF : CMD_NOP;
   assign cke_o    = !((st == ST_SRE) || (st == ST_SELF));
   assign req_o    = (st != ST_IDLE);
   assign ack_o    = (st == ST_SELF);

   // R2: refresh follows a granted, all-idle cycle with clock enabled
   a_r2_ref_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_REF && cke_o) |-> $past(gnt_i && idle_i && cke_o));
   // R7: self-refresh entry follows a granted, all-idle cycle with sleep requested
   a_r7_entry_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_REF && !cke_o) |-> $past(gnt_i && idle_i && sleep_req_i));
   // R8: acknowledge rises only while sleep was requested
   a_r8_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(sleep_req_i) && !cke_o);
   // R9: held sleep keeps clock enable low
   a_r9_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && sleep_req_i) |=> (!cke_o && cmd_o == CMD_NOP));
   // R10: clock enable rises only after the sleep request was released
   a_r10_exit_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> $past(!sleep_req_i));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
   import rfsh_pkg::*;
#(
   parameter int CLK_MHZ     = 100,
   parameter int INTERVAL_NS = 15600,
   parameter int WINDOW_US   = 32000,
   parameter int BURST_CNT   = 2048,
   parameter int TRC_NS      = 66
) (
   input  logic clk,
   input  logic rst_n,
   input  logic policy_burst_i,
   input  logic banks_idle_i,
   input  logic rf_gnt_i,
   input  logic sleep_req_i,
   output logic rf_req_o,
   output logic sleep_ack_o,
   output logic cs_n_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o,
   output logic cke_o
);
   localparam int INTERVAL_CYC = (CLK_MHZ * INTERVAL_NS) / 1000;
   localparam int WINDOW_CYC   = CLK_MHZ * WINDOW_US;
   localparam int TRC_CYC      = (CLK_MHZ * TRC_NS + 999) / 1000;
   localparam int DW           = $clog2(BURST_CNT + 1);
   localparam int GW           = $clog2(TRC_CYC + 1);

   if (TRC_CYC < 2) begin : g_bad_trc
      $error("rfsh_sched: tRC must span at least 2 clocks");
   end
   if (BURST_CNT < 1) begin : g_bad_burst
      $error("rfsh_sched: BURST_CNT must be positive");
   end
   if (WINDOW_CYC <= BURST_CNT * (TRC_CYC + 2)) begin : g_bad_window
      $error("rfsh_sched: window too short for one burst");
   end

   logic          tick, take, hold, refill;
   logic [DW-1:0] owed;
   logic [3:0]    cmd;

   rfsh_timer #(.INTERVAL_CYC(INTERVAL_CYC), .WINDOW_CYC(WINDOW_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .hold_i(hold), .burst_i(policy_burst_i), .tick_o(tick)
   );

   rfsh_debt #(.BURST_CNT(BURST_CNT)) u_debt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .burst_i(policy_burst_i),
      .take_i(take), .clr_i(hold), .refill_i(refill), .owed_o(owed)
   );

   rfsh_ctrl #(.TRC_CYC(TRC_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .owed_nz_i(owed != '0), .burst_i(policy_burst_i),
      .gnt_i(rf_gnt_i), .idle_i(banks_idle_i), .sleep_req_i(sleep_req_i),
      .take_o(take), .hold_o(hold), .refill_o(refill), .cmd_o(cmd),
      .cke_o(cke_o), .req_o(rf_req_o), .ack_o(sleep_ack_o)
   );

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

   // quiet-time checker: cycles since last refresh or clock-enable rise
   logic          cke_q;
   logic [GW-1:0] gap;
   logic          ar_now;

   assign ar_now = (cmd == CMD_REF) && cke_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q <= 1'b1;
         gap   <= GW'(TRC_CYC);
      end else begin
         cke_q <= cke_o;
         if (ar_now || (cke_o && !cke_q)) gap <= GW'(1);
         else if (gap != GW'(TRC_CYC))    gap <= gap + 1'b1;
      end
   end

   // R5 / R10: no refresh within tRC of a refresh or of leaving self-refresh
   a_r5_trc_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ar_now |-> gap == GW'(TRC_CYC));
   // R10: clock enable high again means acknowledge is gone
   a_r10_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_o && !cke_q) |-> !sleep_ack_o);
endmodule

// File: tb/sim_rfsh_sched.sv
module sim_rfsh_sched;
   localparam int INTV = 20;
   localparam int WIN  = 300;
   localparam int NB   = 4;
   localparam int TRC  = 3;

   typedef struct packed {
      logic pol;
      logic gnt;
      logic idle;
      int   cyc;
      int   exp;
   } vec_t;

   localparam vec_t VT [6] = '{
      '{1'b0, 1'b1, 1'b1, 110, 5},
      '{1'b0, 1'b1, 1'b1, 50,  2},
      '{1'b1, 1'b1, 1'b1, 330, 4},
      '{1'b1, 1'b1, 1'b1, 290, 0},
      '{1'b0, 1'b0, 1'b1, 110, 0},
      '{1'b0, 1'b1, 1'b0, 110, 0}
   };

   logic clk = 1'b0;
   logic rst_n, pol, idle, gnt, sleep;
   logic req, ack, cs_n, ras_n, cas_n, we_n, cke;

   always #5 clk = ~clk;

   rfsh_sched #(
      .CLK_MHZ(100), .INTERVAL_NS(200), .WINDOW_US(3), .BURST_CNT(NB), .TRC_NS(30)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .policy_burst_i(pol), .banks_idle_i(idle),
      .rf_gnt_i(gnt), .sleep_req_i(sleep), .rf_req_o(req), .sleep_ack_o(ack),
      .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .cke_o(cke)
   );

   int checks = 0, fails = 0;
   int cyc = 0, ar_cnt = 0, sre_cnt = 0, ar_prev = 0, ar_first = 0, last_gap = 0;
   bit done = 0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && {cs_n, ras_n, cas_n, we_n} == 4'b0001) begin
         if (cke) begin
            if (ar_cnt == 0) ar_first <= cyc;
            else             last_gap <= cyc - ar_prev;
            ar_prev <= cyc;
            ar_cnt  <= ar_cnt + 1;
         end else begin
            sre_cnt <= sre_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_counts();
      @(negedge clk);
      ar_cnt = 0; sre_cnt = 0; last_gap = 0;
   endtask

   task automatic do_reset(input logic p, input logic g, input logic i);
      @(negedge clk);
      rst_n = 1'b0; pol = p; gnt = g; idle = i; sleep = 1'b0;
      cycles(3);
      rst_n = 1'b1;
      ar_cnt = 0; sre_cnt = 0; last_gap = 0;
   endtask

   initial begin
      int n0;
      rst_n = 1'b0; pol = 1'b0; gnt = 1'b0; idle = 1'b1; sleep = 1'b0;
      cycles(3);
      // R1: reset state
      chk(cke == 1'b1, "R1 cke in reset", int'(cke), 1);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop in reset",
          int'({cs_n, ras_n, cas_n, we_n}), 7);
      chk(req == 1'b0 && ack == 1'b0, "R1 req/ack in reset", int'({req, ack}), 0);
      rst_n = 1'b1;
      cycles(2);
      chk({cs_n, ras_n, cas_n, we_n, cke, req, ack} == 7'b0111100, "R1 after reset",
          int'({cs_n, ras_n, cas_n, we_n, cke, req, ack}), 7'b0111100);

      // table walk: R2 R3 R4 refresh counts per policy and gating
      for (int k = 0; k < 6; k++) begin
         do_reset(VT[k].pol, VT[k].gnt, VT[k].idle);
         cycles(VT[k].cyc);
         chk(ar_cnt == VT[k].exp, $sformatf("R3/R4/R2 vector %0d refresh count", k),
             ar_cnt, VT[k].exp);
      end

      // R6: request while owed, refresh after grant, release afterwards
      do_reset(1'b0, 1'b0, 1'b1);
      cycles(25);
      chk(req == 1'b1, "R6 request while owed", int'(req), 1);
      chk(ar_cnt == 0, "R2 no refresh without grant", ar_cnt, 0);
      gnt = 1'b1;
      cycles(3);
      chk(ar_cnt == 1, "R2 refresh after grant", ar_cnt, 1);
      cycles(3);
      chk(req == 1'b0, "R6 request released", int'(req), 0);

      // R4 R5: burst spacing and window repeat
      do_reset(1'b1, 1'b1, 1'b1);
      cycles(330);
      chk(last_gap == TRC, "R5 spacing inside burst", last_gap, TRC);
      cycles(300);
      chk(ar_cnt == 2 * NB, "R4 second window", ar_cnt, 2 * NB);

      // R3: saturation after a long denial
      do_reset(1'b0, 1'b0, 1'b1);
      cycles(118);
      gnt = 1'b1;
      ar_cnt = 0;
      cycles(20);
      chk(ar_cnt == NB + 1, "R3 saturated debt", ar_cnt, NB + 1);
      chk(last_gap == TRC, "R5 spacing of drained debt", last_gap, TRC);

      // R7 R8 R9 R10: sleep beats pending refresh, distributed policy
      do_reset(1'b0, 1'b0, 1'b1);
      cycles(30);
      chk(ack == 1'b0, "R8 no ack before sleep", int'(ack), 0);
      sleep = 1'b1; gnt = 1'b1;
      cycles(4);
      chk(sre_cnt == 1, "R7 entry issued", sre_cnt, 1);
      chk(ar_cnt == 0, "R7 sleep precedes owed refresh", ar_cnt, 0);
      chk(ack == 1'b1 && cke == 1'b0, "R8 ack with cke low", int'({ack, cke}), 2);
      gnt = 1'b0; idle = 1'b0; pol = 1'b1;
      cycles(60);
      chk(cke == 1'b0 && ack == 1'b1, "R9 still asleep", int'({ack, cke}), 2);
      chk(ar_cnt == 0 && sre_cnt == 1, "R9 no commands while asleep", ar_cnt + sre_cnt, 1);
      gnt = 1'b1; idle = 1'b1; pol = 1'b0;
      clr_counts();
      sleep = 1'b0;
      cycles(1);
      chk(cke == 1'b1 && ack == 1'b0, "R10 exit next clock", int'({ack, cke}), 1);
      cycles(14);
      chk(ar_cnt == 0, "R11 no recovery burst, R7 debt dropped", ar_cnt, 0);

      // R11: recovery burst under burst policy
      do_reset(1'b1, 1'b1, 1'b1);
      sleep = 1'b1;
      cycles(5);
      chk(ack == 1'b1, "R8 ack in burst policy", int'(ack), 1);
      clr_counts();
      n0 = cyc;
      sleep = 1'b0;
      cycles(20);
      chk(ar_cnt == NB, "R11 recovery burst count", ar_cnt, NB);
      chk(ar_first - n0 >= TRC + 1, "R10 quiet after exit", ar_first - n0, TRC + 1);
      chk(last_gap == TRC, "R11 recovery spacing", last_gap, TRC);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule